// File: doc/BRIEF.md
# Serial Access Port Controller

This block is the serial side of a dual-port video memory. It holds a data register of `DEPTH` words of `WIDTH` bits and a wrapping address pointer, all clocked by the serial clock. Each rising serial clock edge either streams one word out towards the pins or captures one word from them. The direction depends on the kind of the most recent transfer event. An active-low serial enable gates the pin drivers in the outgoing direction and masks word captures in the incoming direction. The pointer advances on every serial edge whatever the enable level, so the enable works as a per-word skip mask during serial writes.

A transfer event sets the pointer to a supplied start address and chooses the direction. The memory-array side fills the register through a parallel load port, one word per edge. The pins are presented pad-side as separate input, output and output-enable vectors, and the pad ring resolves them into the bidirectional bus. An output flag reports whether the pointer lies in the upper half of the register.

The direction controller is a two-state machine. `ST_INPUT` is the reset state: pins are inputs and serial writes are allowed. `ST_OUTPUT` means pins are outputs and serial reads take place. The transitions are named by transfer kind. TX_READ (kind 00) enters `ST_OUTPUT`. TX_WRITE (01) and TX_PSEUDO (10) enter `ST_INPUT`. Kind 11 is reserved and leaves the state where it is.

Top module: `sam_port_ctrl`

## Requirements
- R1: After reset the direction is `ST_INPUT`, the pointer is 0, `half_flag` is 0 and `sio_oe` is 0.
- R2: On an edge with `xfer_valid` high and kind 00, the port enters `ST_OUTPUT`. With kind 01 or 10 it enters `ST_INPUT`. In every accepted case the pointer is loaded with `xfer_start`, and no serial access occurs on that edge.
- R3: A transfer with kind 11 is ignored. Direction and pointer behave as if `xfer_valid` were low, and that edge performs a normal serial access.
- R4: In `ST_OUTPUT`, each non-transfer edge places the word at the pointer on `sio_o`, and the pointer advances.
- R5: In `ST_INPUT` with `se_n` low, each non-transfer edge stores `sio_i` at the pointer.
- R6: While `se_n` is high, `sio_oe` is 0. In `ST_INPUT` no word is stored. `sio_oe` is 1 exactly when the state is `ST_OUTPUT` and `se_n` is low.
- R7: The pointer advances on every non-transfer edge regardless of `se_n`, and it wraps from `DEPTH-1` to 0.
- R8: `half_flag` is 1 exactly when the pointer is at least `DEPTH/2`. It rises after address `DEPTH/2-1` is accessed and falls after address `DEPTH-1` is accessed.
- R9: With `load_we` high, `load_data` is written at `load_addr` on the edge. If a serial write targets the same address on the same edge, the serial word is kept.
- R10: A serial read of an address that the parallel port loads on the same edge returns the contents from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sc | input | 1 | Serial clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| se_n | input | 1 | Serial enable, active low |
| sio_i | input | WIDTH | Word from the serial pins |
| sio_o | output | WIDTH | Word towards the serial pins |
| sio_oe | output | 1 | Pin driver enable |
| xfer_valid | input | 1 | Transfer event on this edge |
| xfer_kind | input | 2 | 00 read, 01 write, 10 pseudo, 11 reserved |
| xfer_start | input | PTR_W | Pointer start address for the transfer |
| load_we | input | 1 | Parallel load strobe |
| load_addr | input | PTR_W | Parallel load address |
| load_data | input | WIDTH | Parallel load word |
| half_flag | output | 1 | Pointer is in the upper half |

## Verification
The parallel load port can hit the word the serial side touches on the same edge. In `ST_INPUT` that is a write against a write. In `ST_OUTPUT` it is a load against a read. The bench provokes both by aiming about half of its loads at its own model's pointer, in long write and read stretches with a random enable. The model stores the serial word on a write clash and returns the old word on a read clash. The data later read back, or read on that edge, is judged against the model and tagged by the kind of collision that produced it.

// File: rtl/sam_pkg.sv
package sam_pkg;

    typedef enum logic [1:0] {
        XK_READ   = 2'b00,
        XK_WRITE  = 2'b01,
        XK_PSEUDO = 2'b10,
        XK_RSVD   = 2'b11
    } xfer_kind_e;

    typedef enum logic {
        ST_INPUT  = 1'b0,
        ST_OUTPUT = 1'b1
    } port_state_e;

endpackage

// File: rtl/sam_dir_fsm.sv
module sam_dir_fsm
    import sam_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       xfer_valid,
    input  logic [1:0] xfer_kind,
    output logic       xfer_take,
    output logic       drive_out
);

    port_state_e state_q, state_d;
    xfer_kind_e  kind;

    assign kind = xfer_kind_e'(xfer_kind);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_INPUT;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        xfer_take = 1'b0;
        if (xfer_valid) begin
            unique case (kind)
                XK_READ:   begin state_d = ST_OUTPUT; xfer_take = 1'b1; end
                XK_WRITE:  begin state_d = ST_INPUT;  xfer_take = 1'b1; end
                XK_PSEUDO: begin state_d = ST_INPUT;  xfer_take = 1'b1; end
                XK_RSVD:   begin state_d = state_q;   xfer_take = 1'b0; end
                default:   begin state_d = state_q;   xfer_take = 1'b0; end
            endcase
        end
        drive_out = (state_q == ST_OUTPUT);
    end

    assert_read_xfer_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && xfer_kind == 2'b00) |=> drive_out);
    assert_write_xfer_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && (xfer_kind == 2'b01 || xfer_kind == 2'b10)) |=> !drive_out);
    assert_rsvd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && xfer_kind == 2'b11) |=> $stable(drive_out));

endmodule

// File: rtl/sam_pointer.sv
module sam_pointer #(
    parameter int DEPTH = 512,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PTR_W-1:0] start,
    output logic [PTR_W-1:0] ptr,
    output logic             half
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [PTR_W-1:0] HALF = PTR_W'(DEPTH / 2);

    logic [PTR_W-1:0] ptr_d;

    always_comb begin
        if (load)             ptr_d = start;
        else if (ptr == LAST) ptr_d = '0;
        else                  ptr_d = ptr + PTR_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr <= '0;
        else        ptr <= ptr_d;
    end

    assign half = (ptr >= HALF);

    assert_load_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ptr == $past(start));
    assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && ptr == LAST) |=> ptr == '0);
    assert_flag_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && ptr == HALF - PTR_W'(1)) |=> half);
    assert_flag_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && ptr == LAST) |=> !half);

endmodule

// File: rtl/sam_store.sv
module sam_store #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 4,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             ld_we,
    input  logic [PTR_W-1:0] ld_addr,
    input  logic [WIDTH-1:0] ld_data,
    output logic [WIDTH-1:0] rd_q
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic             ld_clash;

    assign ld_clash = wr_en && (ld_addr == addr);

    // serial write overrides a same-address parallel load
    always_ff @(posedge clk) begin
        if (ld_we && !ld_clash) mem[ld_addr] <= ld_data;
        if (wr_en)              mem[addr]    <= wr_data;
    end

    // read returns contents from before this edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_q <= '0;
        else if (rd_en) rd_q <= mem[addr];
    end

    assert_serial_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ld_we && ld_addr == addr) |=> mem[$past(addr)] == $past(wr_data));
    assert_no_rw_mix_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en));

endmodule

// File: rtl/sam_port_ctrl.sv
module sam_port_ctrl #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 4,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             sc,
    input  logic             rst_n,
    input  logic             se_n,
    input  logic [WIDTH-1:0] sio_i,
    output logic [WIDTH-1:0] sio_o,
    output logic             sio_oe,
    input  logic             xfer_valid,
    input  logic [1:0]       xfer_kind,
    input  logic [PTR_W-1:0] xfer_start,
    input  logic             load_we,
    input  logic [PTR_W-1:0] load_addr,
    input  logic [WIDTH-1:0] load_data,
    output logic             half_flag
);

    logic             xfer_take;
    logic             drive_out;
    logic [PTR_W-1:0] ptr;
    logic             rd_en;
    logic             wr_en;
    logic [WIDTH-1:0] rd_q;

    sam_dir_fsm u_fsm (
        .clk        (sc),
        .rst_n      (rst_n),
        .xfer_valid (xfer_valid),
        .xfer_kind  (xfer_kind),
        .xfer_take  (xfer_take),
        .drive_out  (drive_out)
    );

    sam_pointer #(.DEPTH(DEPTH)) u_ptr (
        .clk   (sc),
        .rst_n (rst_n),
        .load  (xfer_take),
        .start (xfer_start),
        .ptr   (ptr),
        .half  (half_flag)
    );

    assign rd_en = drive_out && !xfer_take;
    assign wr_en = !drive_out && !xfer_take && !se_n;

    sam_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
        .clk     (sc),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .addr    (ptr),
        .wr_data (sio_i),
        .ld_we   (load_we),
        .ld_addr (load_addr),
        .ld_data (load_data),
        .rd_q    (rd_q)
    );

    assign sio_o  = rd_q;
    assign sio_oe = drive_out && !se_n;

    assert_se_gates_R6: assert property (@(posedge sc) disable iff (!rst_n)
        se_n |-> !sio_oe);
    assert_masked_no_store_R6: assert property (@(posedge sc) disable iff (!rst_n)
        se_n |-> !wr_en);

endmodule

// File: tb/sam_port_ctrl_test.sv
`timescale 1ns/1ps
module sam_port_ctrl_test;
    localparam int DEPTH = 512;
    localparam int WIDTH = 4;

    logic       clk = 0, rst_n = 0, se_n = 1, xfer_valid = 0, load_we = 0;
    logic [1:0] xfer_kind = 0;
    logic [8:0] xfer_start = 0, load_addr = 0;
    logic [3:0] sio_i = 0, load_data = 0;
    logic [3:0] sio_o;
    logic       sio_oe, half_flag;

    int checks = 0, errors = 0;
    int m_mem [DEPTH];
    int m_org [DEPTH];   // 0 none, 1 load, 2 serial, 3 collision
    int m_ptr, m_dout, m_dorg, p;
    bit m_out, m_rsvd, m_took, m_wrap, sw;
    bit in_reset = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #4 clk = ~clk;

    sam_port_ctrl uut (
        .sc(clk), .rst_n(rst_n), .se_n(se_n), .sio_i(sio_i), .sio_o(sio_o),
        .sio_oe(sio_oe), .xfer_valid(xfer_valid), .xfer_kind(xfer_kind),
        .xfer_start(xfer_start), .load_we(load_we), .load_addr(load_addr),
        .load_data(load_data), .half_flag(half_flag)
    );

    function int rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'(seed[30:16]);
    endfunction

    // behavioural reference model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ptr = 0; m_out = 0; m_dout = 0; m_dorg = 0;
            m_rsvd = 0; m_took = 0; m_wrap = 0;
        end else begin
            p = m_ptr; sw = 0; m_wrap = 0;
            m_rsvd = xfer_valid && xfer_kind == 2'b11;
            m_took = xfer_valid && xfer_kind != 2'b11;
            if (m_took) begin
                m_out = (xfer_kind == 2'b00);
                m_ptr = int'(xfer_start);
            end else begin
                if (m_out) begin
                    m_dout = m_mem[p];
                    m_dorg = (load_we && int'(load_addr) == p) ? 4 : m_org[p];
                end else if (!se_n) sw = 1;
                m_wrap = (p == DEPTH - 1);
                m_ptr = (p + 1) % DEPTH;
            end
            if (load_we && !(sw && int'(load_addr) == p)) begin
                m_mem[load_addr] = int'(load_data);
                m_org[load_addr] = 1;
            end
            if (sw) begin
                m_mem[p] = int'(sio_i);
                m_org[p] = (load_we && int'(load_addr) == p) ? 3 : 2;
            end
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic sample();
        bit    exp_oe;
        string t;
        exp_oe = m_out && !se_n;
        if (in_reset)    t = "R1";
        else if (m_rsvd) t = "R3";
        else if (m_took) t = "R2";
        else if (se_n)   t = "R6";
        else             t = "R4";
        chk(sio_oe == exp_oe, t, int'(sio_oe), int'(exp_oe));
        if (exp_oe) begin
            case (m_dorg)
                4: t = "R10";
                3: t = "R9";
                2: t = "R5";
                default: t = "R4";
            endcase
            chk(int'(sio_o) == m_dout, t, int'(sio_o), m_dout);
        end
        if (in_reset)    t = "R1";
        else if (m_wrap) t = "R7";
        else if (m_rsvd) t = "R3";
        else             t = "R8";
        chk(half_flag == (m_ptr >= DEPTH / 2), t, int'(half_flag), int'(m_ptr >= DEPTH / 2));
    endtask

    task automatic step(bit xv, int k, int st, bit se, int d, bit lw, int la, int ld);
        xfer_valid = xv; xfer_kind = 2'(k); xfer_start = 9'(st); se_n = se;
        sio_i = 4'(d); load_we = lw; load_addr = 9'(la); load_data = 4'(ld);
        @(negedge clk);
        sample();
    endtask

    task automatic busy(int n, int xrate);
        for (int i = 0; i < n; i++) begin
            bit xv;
            int la;
            xv = (xrate != 0) && (rnd() % xrate == 0);
            la = (rnd() % 2 == 0) ? m_ptr : rnd() % DEPTH;
            step(xv, rnd() % 4, rnd() % DEPTH, rnd() % 4 == 0, rnd() % 16,
                 rnd() % 3 == 0, la, rnd() % 16);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1; in_reset = 1;
        #1 sample();                        // R1 reset state
        in_reset = 0;
        @(negedge clk); sample();
        // fill register through the parallel port
        for (int a = 0; a < DEPTH; a++) step(0, 0, 0, 1, 0, 1, a, (a * 7 + 3) % 16);
        // read transfer near the half boundary (R2, R4, R8)
        step(1, 0, 250, 0, 0, 0, 0, 0);
        for (int i = 0; i < 20; i++) step(0, 0, 0, i % 5 == 2, 0, 0, 0, 0);
        // read across the wrap with a reserved kind mid-way (R3, R7)
        step(1, 0, 500, 0, 0, 0, 0, 0);
        for (int i = 0; i < 20; i++)
            step(i == 5, 3, 77, i % 4 == 1, 0, 0, 0, 0);
        // write transfer then serial writes with masks and clashes (R5, R6, R9)
        step(1, 1, 0, 0, 0, 0, 0, 0);
        busy(600, 0);
        // pseudo transfer (R2)
        step(1, 2, 300, 0, 0, 0, 0, 0);
        busy(100, 0);
        // read everything back with same-edge loads (R10)
        step(1, 0, 0, 0, 0, 0, 0, 0);
        busy(600, 0);
        // mixed traffic
        busy(2000, 50);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule